// File: doc/BRIEF.md
# Skewed Pipelined Four-Row Column Adder

This block adds four unsigned operand rows one column at a time and, once its pipeline has filled, delivers one column total per clock. A column is offered as four row values together with a valid flag. The block skews the rows internally and pads the unused slots with zeros, so the caller always presents all four values of a column in the same cycle. The caller never staggers them.

Two adder arrangements share the same three registered adders, and a mode input selects one of them. In the chain arrangement, the first adder sums rows 0 and 1. The second adder adds row 2, delayed one clock, to that partial sum. The third adder adds row 3, delayed two clocks. In the tree arrangement, rows 0+1 and rows 2+3 are summed side by side, and the third adder combines the two partial sums. The chain arrangement takes one clock longer than the tree. A valid bit travels with each column, so the output flag marks each finished total exactly. The mode may only be changed while no column is in flight.

Top module: `skewed_col_adder`

## Requirements
- R1: With mode_tree_i=0 (chain), a column accepted on a rising edge (in_valid_i=1) shows its total row0+row1+row2+row3 on sum_o with out_valid_o=1 just after the third rising edge, counting the accepting edge as the first.
- R2: With mode_tree_i=1 (tree), a column accepted on a rising edge shows its total on sum_o with out_valid_o=1 just after the second rising edge, counting the accepting edge as the first.
- R3: sum_o is DATA_W+2 bits wide, and four operands all equal to 2^DATA_W-1 give 4*(2^DATA_W-1) with no truncation, in either mode.
- R4: Columns accepted on consecutive edges come out on consecutive cycles in their input order, one total per clock, in either mode.
- R5: In a cycle with in_valid_i=0, the row inputs are ignored: they create no output and change no other column's total.
- R6: While rst_n is low, out_valid_o is 0 and sum_o is 0.
- R7: When the mode changes while the pipeline is empty, the next column follows the latency and total of the newly selected mode.
- R8: In every cycle where out_valid_o is 0, sum_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_tree_i | input | 1 | 0 selects the chain arrangement, 1 selects the tree; changed only while empty |
| in_valid_i | input | 1 | Column on the row inputs is accepted this edge |
| row0_i | input | DATA_W | Column operand, row 0 |
| row1_i | input | DATA_W | Column operand, row 1 |
| row2_i | input | DATA_W | Column operand, row 2 |
| row3_i | input | DATA_W | Column operand, row 3 |
| out_valid_o | output | 1 | sum_o holds a finished column total |
| sum_o | output | DATA_W+2 | Column total |

## Verification
The hardest case to reach from the ports is a bubble inside a chain-mode burst. In that case, a skewed row 2 or row 3 value of one column shares an adder with the zero padding of its neighbour. Garbage row data left on the inputs during the bubble would corrupt the neighbour's total unless the padding is truly zero. The stimulus therefore alternates valid and invalid cycles in chain mode with random non-zero data held on all rows in the idle cycles. It also drives maximum-value columns and back-to-back bursts in both modes. The mode is switched only after draining the pipeline, so the change of latency is seen on the very next column.

// File: rtl/cadd_pkg.sv
`timescale 1ns/1ps
package cadd_pkg;

    typedef enum logic {
        MODE_CHAIN = 1'b0,
        MODE_TREE  = 1'b1
    } cadd_mode_e;

endpackage

// File: rtl/cadd_delay.sv
`timescale 1ns/1ps
// Zero-filling delay line used to stagger one operand row.
module cadd_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] tap;
    } line_t;

    line_t line_d, line_q;

    always_comb begin
        line_d        = line_q;
        line_d.tap[0] = load_i ? d_i : '0;
        for (int i = 1; i < DEPTH; i++) begin
            line_d.tap[i] = line_q.tap[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line_d;
    end

    assign q_o = line_q.tap[DEPTH-1];

    // R5
    skew_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> (line_q.tap[0] == '0));

endmodule

// File: rtl/cadd_stage.sv
`timescale 1ns/1ps
// One registered adder unit.
module cadd_stage #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] op_a_i,
    input  logic [W-1:0] op_b_i,
    output logic [W-1:0] sum_o
);

    typedef struct packed {
        logic [W-1:0] sum;
    } stage_t;

    stage_t stage_d, stage_q;

    always_comb begin
        stage_d.sum = op_a_i + op_b_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign sum_o = stage_q.sum;

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (stage_q.sum >= $past(op_a_i)) && (stage_q.sum >= $past(op_b_i)));

endmodule

// File: rtl/cadd_valid.sv
`timescale 1ns/1ps
// Valid-bit pipeline that follows the column through the selected arrangement.
module cadd_valid
    import cadd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  cadd_mode_e mode_i,
    input  logic       in_valid_i,
    output logic       out_valid_o
);

    typedef struct packed {
        logic v1;
        logic v2;
        logic vo;
    } vpipe_t;

    vpipe_t vp_d, vp_q;

    always_comb begin
        vp_d.v1 = in_valid_i;
        vp_d.v2 = vp_q.v1 && (mode_i == MODE_CHAIN);
        vp_d.vo = (mode_i == MODE_TREE) ? vp_q.v1 : vp_q.v2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) vp_q <= '0;
        else        vp_q <= vp_d;
    end

    assign out_valid_o = vp_q.vo;

    // R7
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vp_q.v1 || vp_q.v2) |-> $stable(mode_i));

    // R1
    chain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vp_q.v2 && mode_i == MODE_CHAIN) |=> out_valid_o);

    // R2
    tree_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vp_q.v1 && mode_i == MODE_TREE) |=> out_valid_o);

endmodule

// File: rtl/skewed_col_adder.sv
`timescale 1ns/1ps
module skewed_col_adder
    import cadd_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_tree_i,
    input  logic              in_valid_i,
    input  logic [DATA_W-1:0] row0_i,
    input  logic [DATA_W-1:0] row1_i,
    input  logic [DATA_W-1:0] row2_i,
    input  logic [DATA_W-1:0] row3_i,
    output logic              out_valid_o,
    output logic [DATA_W+1:0] sum_o
);

    localparam int SUM_W  = DATA_W + 2;
    localparam int PAD_W  = SUM_W - DATA_W;
    localparam int ROWS   = 4;
    localparam int SKEWED = ROWS - 2;

    typedef struct packed {
        logic [SUM_W-1:0] a_x, a_y;
        logic [SUM_W-1:0] b_x, b_y;
        logic [SUM_W-1:0] c_x, c_y;
    } route_t;

    cadd_mode_e        mode_e;
    logic [DATA_W-1:0] gated   [ROWS];
    logic [DATA_W-1:0] skewed  [SKEWED];
    logic [SUM_W-1:0]  part1_q, part2_q, total_q;
    logic              skew_load;
    route_t            route_d;

    assign mode_e    = cadd_mode_e'(mode_tree_i);
    assign skew_load = in_valid_i && (mode_e == MODE_CHAIN);

    // Zero padding: operands of an empty slot are forced to zero.
    assign gated[0] = in_valid_i ? row0_i : '0;
    assign gated[1] = in_valid_i ? row1_i : '0;
    assign gated[2] = in_valid_i ? row2_i : '0;
    assign gated[3] = in_valid_i ? row3_i : '0;

    // Row 2 is held back one clock and row 3 two clocks in chain mode.
    for (genvar g = 0; g < SKEWED; g++) begin : g_skew
        cadd_delay #(.W(DATA_W), .DEPTH(g + 1)) u_skew (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (skew_load),
            .d_i    (gated[g + 2]),
            .q_o    (skewed[g])
        );
    end

    always_comb begin
        route_d.a_x = {{PAD_W{1'b0}}, gated[0]};
        route_d.a_y = {{PAD_W{1'b0}}, gated[1]};
        if (mode_e == MODE_CHAIN) begin
            route_d.b_x = part1_q;
            route_d.b_y = {{PAD_W{1'b0}}, skewed[0]};
            route_d.c_x = part2_q;
            route_d.c_y = {{PAD_W{1'b0}}, skewed[1]};
        end else begin
            route_d.b_x = {{PAD_W{1'b0}}, gated[2]};
            route_d.b_y = {{PAD_W{1'b0}}, gated[3]};
            route_d.c_x = part1_q;
            route_d.c_y = part2_q;
        end
    end

    cadd_stage #(.W(SUM_W)) u_add_a (
        .clk(clk), .rst_n(rst_n),
        .op_a_i(route_d.a_x), .op_b_i(route_d.a_y), .sum_o(part1_q));

    cadd_stage #(.W(SUM_W)) u_add_b (
        .clk(clk), .rst_n(rst_n),
        .op_a_i(route_d.b_x), .op_b_i(route_d.b_y), .sum_o(part2_q));

    cadd_stage #(.W(SUM_W)) u_add_c (
        .clk(clk), .rst_n(rst_n),
        .op_a_i(route_d.c_x), .op_b_i(route_d.c_y), .sum_o(total_q));

    cadd_valid u_valid (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode_e),
        .in_valid_i  (in_valid_i),
        .out_valid_o (out_valid_o)
    );

    assign sum_o = total_q;

    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid_o |-> (sum_o == '0));

endmodule

// File: tb/tb_skewed_col_adder.sv
`timescale 1ns/1ps
module tb_skewed_col_adder;

    localparam int DW = 8;
    localparam int SW = DW + 2;
    localparam int MX = (1 << DW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode = 1'b0;
    logic          vin = 1'b0;
    logic [DW-1:0] r0 = '0, r1 = '0, r2 = '0, r3 = '0;
    logic          vout;
    logic [SW-1:0] sum;

    always #2.5 clk = ~clk;

    skewed_col_adder #(.DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .mode_tree_i(mode), .in_valid_i(vin),
        .row0_i(r0), .row1_i(r1), .row2_i(r2), .row3_i(r3),
        .out_valid_o(vout), .sum_o(sum));

    int    cyc = 0;
    int    total = 0;
    int    bad = 0;
    bit    chk_en = 1'b0;
    bit    done = 1'b0;
    string tag = "R1";
    int    due_q[$];
    int    val_q[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", rq, act, exp, cyc);
        end
    endtask

    // Reference model: each accepted column is due a fixed number of edges later.
    always @(negedge clk) begin
        if (chk_en) begin
            if (due_q.size() > 0 && due_q[0] == cyc) begin
                check(vout === 1'b1, tag, int'(vout), 1);
                check(sum === SW'(val_q[0]), tag, int'(sum), val_q[0]);
                void'(due_q.pop_front());
                void'(val_q.pop_front());
            end else begin
                // R8 and R5: nothing due, so no valid and a zero total
                check(vout === 1'b0, "R5", int'(vout), 0);
                check(sum === '0, "R8", int'(sum), 0);
            end
        end
    end

    task automatic step(input bit v, input int a, input int b, input int c, input int d);
        @(negedge clk);
        vin = v;
        r0 = DW'(a); r1 = DW'(b); r2 = DW'(c); r3 = DW'(d);
        if (v) begin
            due_q.push_back(cyc + (mode ? 2 : 3));
            val_q.push_back(a + b + c + d);
        end
    endtask

    task automatic rnd_col(input bit v);
        step(v, int'($urandom_range(0, MX)), int'($urandom_range(0, MX)),
                int'($urandom_range(0, MX)), int'($urandom_range(0, MX)));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) rnd_col(1'b0);
    endtask

    task automatic set_mode(input bit m);
        idle(4);
        @(negedge clk);
        vin  = 1'b0;
        mode = m;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
        finish_run();
    end

    initial begin
        // R6: outputs idle while reset is held
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(vout === 1'b0, "R6", int'(vout), 0);
            check(sum === '0, "R6", int'(sum), 0);
        end
        @(negedge clk);
        rst_n  = 1'b1;
        chk_en = 1'b1;

        // R1: single chain columns, three edges of latency
        tag = "R1";
        step(1, 3, 5, 7, 9);
        idle(5);
        for (int i = 0; i < 6; i++) begin rnd_col(1'b1); idle(3); end

        // R4: back-to-back chain burst
        tag = "R4";
        for (int i = 0; i < 8; i++) rnd_col(1'b1);
        idle(5);

        // R5: bubbles with garbage rows between chain columns
        tag = "R5";
        for (int i = 0; i < 10; i++) begin rnd_col(1'b1); rnd_col(1'b0); end
        for (int i = 0; i < 6; i++) begin rnd_col(1'b1); rnd_col(1'b1); rnd_col(1'b0); end
        idle(5);

        // R3: maximum operands in chain mode
        tag = "R3";
        step(1, MX, MX, MX, MX);
        step(1, MX, MX, MX, MX);
        step(1, 0, 0, 0, 0);
        idle(5);

        // R7: switch to tree while empty
        set_mode(1'b1);
        tag = "R7";
        step(1, 10, 20, 30, 40);
        idle(4);

        // R2: single tree columns, two edges of latency
        tag = "R2";
        for (int i = 0; i < 6; i++) begin rnd_col(1'b1); idle(2); end

        // R4: tree burst, then bubbles
        tag = "R4";
        for (int i = 0; i < 8; i++) rnd_col(1'b1);
        for (int i = 0; i < 6; i++) begin rnd_col(1'b1); rnd_col(1'b0); end
        idle(4);

        // R3: maximum operands in tree mode
        tag = "R3";
        step(1, MX, MX, MX, MX);
        step(1, MX, 0, MX, 0);
        idle(4);

        // R7: back to chain while empty
        set_mode(1'b0);
        tag = "R7";
        step(1, 1, 2, 4, 8);
        rnd_col(1'b1);
        idle(6);

        // R4: every expected total was delivered
        check(due_q.size() == 0, "R4", due_q.size(), 0);
        chk_en = 1'b0;
        finish_run();
    end

endmodule